// File: doc/BRIEF.md
# DMA Logical-to-Physical Page Translator

This block sits between the I/O channels of a DMA engine and main memory. A channel presents a 24-bit logical address, and the block returns the matching 29-bit physical address. It splits the logical address into a page index and an in-page offset. It finds the frame for that page in a translation table that lives in main memory, and puts the logical offset into the low bits of the frame to form the result.

Software sets up the table through a small register interface. One register holds the physical start of the table. A second holds the table size in bytes. A write of any value to a third register discards every cached translation. A fourth register holds the logical address of the last out-of-range request and can be read back. Recent translations are kept in a four-way, fully associative cache with round-robin replacement. On a miss the block reads the table entry over a valid/ready read port and holds the requesting channel until the data returns.

Top module: `dma_xlat`

## Requirements
- R1: After reset, base, limit and fault registers read 0, the cache holds no entries, `addr_err_o` is 0, `xl_done` is 0 and `xl_ready` is 1.
- R2: Config address 0 holds the table base. Only bits [28:0] of a write are kept, so writing 0xFFFFFFFF reads back 0x1FFFFFFF. Address 1 holds the 32-bit limit. Address 2 (invalidate) always reads 0. Address 3 reads the fault address, zero-extended.
- R3: A request whose index times 8 is at or above the limit completes one cycle after acceptance with `xl_fault`=1 and `xl_paddr`=0. It issues no table read, sets `addr_err_o` and latches the logical address into the fault register. An index whose entry ends exactly at the limit (index times 8 equal to limit minus 8) is in range.
- R4: `addr_err_o` stays set through later requests, including successful ones, until a write to config address 3 clears it.
- R5: A cache miss issues exactly one table read at address base + index×8. It holds `tbl_rd_valid` and the address stable until `tbl_rd_ready`, then waits for `tbl_rsp_valid`.
- R6: The result is `{entry[28:12], laddr[11:0]}`. Entry bits [31:29] and [11:0] are ignored. `xl_fault` is 0.
- R7: A request that hits the cache completes one cycle after acceptance, with no table read.
- R8: The cache holds 4 pages. When it is full, a new fill replaces the entry filled earliest, and hits do not change the replacement order.
- R9: A write to config address 2, with any data, empties the cache, so the next request to any page reads the table again.
- R10: An invalidate that lands while a table read is outstanding does not stop that request from completing with the fetched frame. The fetched entry is not installed in the cache.
- R11: `xl_ready` is 0 from the acceptance of a miss until its result is delivered. Only one table read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 2 | Config register select |
| cfg_wdata | input | 32 | Config write data |
| cfg_rdata | output | 32 | Config read data (combinational) |
| xl_valid | input | 1 | Translation request valid |
| xl_ready | output | 1 | Translator can accept a request |
| xl_laddr | input | 24 | Logical address to translate |
| xl_done | output | 1 | One-cycle pulse: result is valid |
| xl_fault | output | 1 | Result is an out-of-range error |
| xl_paddr | output | 29 | Translated physical address |
| tbl_rd_valid | output | 1 | Table read request valid |
| tbl_rd_ready | input | 1 | Memory accepts the table read |
| tbl_rd_addr | output | 29 | Physical address of the table entry |
| tbl_rsp_valid | input | 1 | Table read data valid |
| tbl_rsp_data | input | 32 | Table read data (frame word) |
| addr_err_o | output | 1 | Sticky address-error flag |

## Verification
The assertions check several rules on every cycle. A rejected index never starts a table read, and a hit completes in one cycle. A pending read holds its address. The request side is closed while a read is outstanding. The error flag only drops on a clear write, and an invalidate leaves every way empty on the next cycle. Only the bench's scenarios can show the rest. Those are the composed physical addresses, round-robin eviction as opposed to least-recently-used eviction, the exact limit boundary, the fault address readback, and a fetch that completes after an invalidate and is not installed. The bench shows these last points by counting table reads on later requests.

// File: rtl/dma_xlat_pkg.sv
package dma_xlat_pkg;
  localparam int CFG_AW = 2;
  localparam int CFG_DW = 32;

  localparam logic [CFG_AW-1:0] CFG_BASE  = 2'd0;
  localparam logic [CFG_AW-1:0] CFG_LIMIT = 2'd1;
  localparam logic [CFG_AW-1:0] CFG_INVAL = 2'd2;
  localparam logic [CFG_AW-1:0] CFG_FAULT = 2'd3;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_WAIT = 2'd2
  } xl_state_t;
endpackage

// File: rtl/dma_xlat_regs.sv
module dma_xlat_regs
  import dma_xlat_pkg::*;
#(
  parameter int PA_W = 29,
  parameter int LA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] rdata,
  input  logic              fault_set,
  input  logic [LA_W-1:0]   fault_laddr,
  output logic [PA_W-1:0]   base,
  output logic [CFG_DW-1:0] limit,
  output logic              inv_pulse,
  output logic              err_clr,
  output logic              err_flag
);
  logic [PA_W-1:0]   base_q;
  logic [CFG_DW-1:0] limit_q;
  logic [LA_W-1:0]   fault_q;
  logic              flag_q;

  assign inv_pulse = we && (addr == CFG_INVAL);
  assign err_clr   = we && (addr == CFG_FAULT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
      fault_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (we && addr == CFG_BASE)  base_q  <= wdata[PA_W-1:0];
      if (we && addr == CFG_LIMIT) limit_q <= wdata;
      if (fault_set) begin
        fault_q <= fault_laddr;
        flag_q  <= 1'b1;
      end else if (err_clr) begin
        flag_q  <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr)
      CFG_BASE:  rdata = CFG_DW'(base_q);
      CFG_LIMIT: rdata = limit_q;
      CFG_FAULT: rdata = CFG_DW'(fault_q);
      default:   rdata = '0;
    endcase
  end

  assign base     = base_q;
  assign limit    = limit_q;
  assign err_flag = flag_q;
endmodule

// File: rtl/dma_xlat_tcache.sv
module dma_xlat_tcache #(
  parameter int IDX_W = 12,
  parameter int FRM_W = 17,
  parameter int WAYS  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_hit,
  output logic [FRM_W-1:0] lk_frame,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [FRM_W-1:0] fill_frame,
  input  logic             flush,
  output logic [WAYS-1:0]  way_valid,
  output logic [WAYS-1:0]  hit_vec
);
  localparam int PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [IDX_W-1:0] tag_q   [WAYS];
  logic [FRM_W-1:0] frame_q [WAYS];
  logic [WAYS-1:0]  vld_q;
  logic [PTR_W-1:0] ptr_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w] = vld_q[w] && (tag_q[w] == lk_idx);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[w]   <= 1'b0;
        tag_q[w]   <= '0;
        frame_q[w] <= '0;
      end else if (flush) begin
        vld_q[w]   <= 1'b0;
      end else if (fill_en && ptr_q == PTR_W'(w)) begin
        vld_q[w]   <= 1'b1;
        tag_q[w]   <= fill_idx;
        frame_q[w] <= fill_frame;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (fill_en && !flush) begin
      ptr_q <= (ptr_q == PTR_W'(WAYS - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_comb begin
    lk_frame = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) lk_frame = lk_frame | frame_q[w];
    end
  end

  assign lk_hit    = |hit_vec;
  assign way_valid = vld_q;
endmodule

// File: rtl/dma_xlat.sv
module dma_xlat
  import dma_xlat_pkg::*;
#(
  parameter int LA_W   = 24,
  parameter int PA_W   = 29,
  parameter int PAGE_W = 12,
  parameter int ENT_LG = 3,
  parameter int WAYS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              xl_valid,
  output logic              xl_ready,
  input  logic [LA_W-1:0]   xl_laddr,
  output logic              xl_done,
  output logic              xl_fault,
  output logic [PA_W-1:0]   xl_paddr,
  output logic              tbl_rd_valid,
  input  logic              tbl_rd_ready,
  output logic [PA_W-1:0]   tbl_rd_addr,
  input  logic              tbl_rsp_valid,
  input  logic [31:0]       tbl_rsp_data,
  output logic              addr_err_o
);
  localparam int IDX_W = LA_W - PAGE_W;
  localparam int FRM_W = PA_W - PAGE_W;

  function automatic logic [IDX_W-1:0] page_of(input logic [LA_W-1:0] la);
    return la[LA_W-1:PAGE_W];
  endfunction

  function automatic logic [PAGE_W-1:0] offset_of(input logic [LA_W-1:0] la);
    return la[PAGE_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] b,
                                                 input logic [IDX_W-1:0] ix);
    return b + PA_W'({ix, {ENT_LG{1'b0}}});
  endfunction

  function automatic logic past_limit(input logic [IDX_W-1:0] ix,
                                      input logic [CFG_DW-1:0] lim);
    return CFG_DW'({ix, {ENT_LG{1'b0}}}) >= lim;
  endfunction

  function automatic logic [PA_W-1:0] compose(input logic [FRM_W-1:0] f,
                                              input logic [PAGE_W-1:0] o);
    return {f, o};
  endfunction

  // register file
  logic [PA_W-1:0]   base;
  logic [CFG_DW-1:0] limit;
  logic              inv_pulse;
  logic              err_clr;
  logic              err_acc;

  dma_xlat_regs #(.PA_W(PA_W), .LA_W(LA_W)) regs_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (cfg_we),
    .addr        (cfg_addr),
    .wdata       (cfg_wdata),
    .rdata       (cfg_rdata),
    .fault_set   (err_acc),
    .fault_laddr (xl_laddr),
    .base        (base),
    .limit       (limit),
    .inv_pulse   (inv_pulse),
    .err_clr     (err_clr),
    .err_flag    (addr_err_o)
  );

  // control state
  xl_state_t       state_q;
  logic [LA_W-1:0] cur_laddr_q;
  logic            stale_q;
  logic            done_q;
  logic            fault_q;
  logic [PA_W-1:0] paddr_q;

  // named events
  logic             acc;
  logic [IDX_W-1:0] idx_in;
  logic             range_err;
  logic             lk_hit;
  logic [FRM_W-1:0] lk_frame;
  logic             hit_acc;
  logic             miss_acc;
  logic             fetch_ret;
  logic             fill_en;
  logic [FRM_W-1:0] rsp_frame;
  logic [WAYS-1:0]  way_valid;
  logic [WAYS-1:0]  hit_vec;
  logic             unused_rsp_bits;

  assign xl_ready  = (state_q == XS_IDLE);
  assign acc       = xl_valid && xl_ready;
  assign idx_in    = page_of(xl_laddr);
  assign range_err = past_limit(idx_in, limit);
  assign err_acc   = acc && range_err;
  assign hit_acc   = acc && !range_err && lk_hit;
  assign miss_acc  = acc && !range_err && !lk_hit;
  assign fetch_ret = (state_q == XS_WAIT) && tbl_rsp_valid;
  assign fill_en   = fetch_ret && !stale_q && !inv_pulse;
  assign rsp_frame = tbl_rsp_data[PA_W-1:PAGE_W];
  assign unused_rsp_bits = ^{tbl_rsp_data[31:PA_W], tbl_rsp_data[PAGE_W-1:0]};

  dma_xlat_tcache #(.IDX_W(IDX_W), .FRM_W(FRM_W), .WAYS(WAYS)) cache_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_idx     (idx_in),
    .lk_hit     (lk_hit),
    .lk_frame   (lk_frame),
    .fill_en    (fill_en),
    .fill_idx   (page_of(cur_laddr_q)),
    .fill_frame (rsp_frame),
    .flush      (inv_pulse),
    .way_valid  (way_valid),
    .hit_vec    (hit_vec)
  );

  assign tbl_rd_valid = (state_q == XS_REQ);
  assign tbl_rd_addr  = entry_addr(base, page_of(cur_laddr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= XS_IDLE;
      cur_laddr_q <= '0;
      stale_q     <= 1'b0;
    end else begin
      case (state_q)
        XS_IDLE: if (miss_acc) begin
          state_q     <= XS_REQ;
          cur_laddr_q <= xl_laddr;
        end
        XS_REQ:  if (tbl_rd_ready)  state_q <= XS_WAIT;
        XS_WAIT: if (tbl_rsp_valid) state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase
      if (acc)                                   stale_q <= 1'b0;
      else if (inv_pulse && state_q != XS_IDLE)  stale_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      paddr_q <= '0;
    end else begin
      done_q  <= hit_acc || err_acc || fetch_ret;
      fault_q <= err_acc;
      if (err_acc)        paddr_q <= '0;
      else if (hit_acc)   paddr_q <= compose(lk_frame, offset_of(xl_laddr));
      else if (fetch_ret) paddr_q <= compose(rsp_frame, offset_of(cur_laddr_q));
    end
  end

  assign xl_done  = done_q;
  assign xl_fault = fault_q;
  assign xl_paddr = paddr_q;
endmodule

// File: rtl/dma_xlat_chk.sv
module dma_xlat_chk #(
  parameter int PA_W = 29,
  parameter int WAYS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc,
  input logic            range_err,
  input logic            lk_hit,
  input logic            xl_ready,
  input logic            xl_done,
  input logic            xl_fault,
  input logic            tbl_rd_valid,
  input logic            tbl_rd_ready,
  input logic [PA_W-1:0] tbl_rd_addr,
  input logic            err_flag,
  input logic            err_clr,
  input logic            inv_pulse,
  input logic [WAYS-1:0] way_valid,
  input logic [WAYS-1:0] hit_vec
);
  a_r3_no_read_on_range: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && range_err) |=> (!tbl_rd_valid && xl_done && xl_fault && err_flag));

  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  a_r5_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_rd_valid && !tbl_rd_ready) |=> (tbl_rd_valid && $stable(tbl_rd_addr)));

  a_r7_hit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !range_err && lk_hit) |=> (xl_done && !xl_fault && !tbl_rd_valid));

  a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    inv_pulse |=> (way_valid == '0));

  a_r11_closed_while_fetching: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_valid |-> !xl_ready);
endmodule

bind dma_xlat dma_xlat_chk #(.PA_W(PA_W), .WAYS(WAYS)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc          (acc),
  .range_err    (range_err),
  .lk_hit       (lk_hit),
  .xl_ready     (xl_ready),
  .xl_done      (xl_done),
  .xl_fault     (xl_fault),
  .tbl_rd_valid (tbl_rd_valid),
  .tbl_rd_ready (tbl_rd_ready),
  .tbl_rd_addr  (tbl_rd_addr),
  .err_flag     (addr_err_o),
  .err_clr      (err_clr),
  .inv_pulse    (inv_pulse),
  .way_valid    (way_valid),
  .hit_vec      (hit_vec)
);

// File: tb/dma_xlat_tb_top.sv
`timescale 1ns/1ps
module dma_xlat_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        xl_valid = 1'b0;
  logic        xl_ready;
  logic [23:0] xl_laddr = '0;
  logic        xl_done;
  logic        xl_fault;
  logic [28:0] xl_paddr;
  logic        tbl_rd_valid;
  logic        tbl_rd_ready = 1'b0;
  logic [28:0] tbl_rd_addr;
  logic        tbl_rsp_valid = 1'b0;
  logic [31:0] tbl_rsp_data = '0;
  logic        addr_err_o;

  always #2.5 clk = ~clk;

  dma_xlat dut_i (.*);

  int total = 0;
  int bad = 0;
  int n_reads = 0;
  int rd_lat = 0;
  int rsp_lat = 0;
  logic [28:0] last_rd_addr = '0;

  // reference model state
  int  m_cache[$];
  int  m_base = 0;
  int  m_limit = 0;
  bit  m_flag = 0;
  int  m_fault = 0;
  bit  m_inflight = 0;
  bit  m_stale = 0;
  bit  m_done_ok = 0;

  function automatic int frame_of(int idx);
    return (idx * 37 + 5) & 32'h1FFFF;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // table memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (tbl_rd_valid) begin
        repeat (rd_lat) @(negedge clk);
        tbl_rd_ready = 1'b1;
        last_rd_addr = tbl_rd_addr;
        @(negedge clk);
        tbl_rd_ready = 1'b0;
        n_reads++;
        repeat (rsp_lat) @(negedge clk);
        tbl_rsp_valid = 1'b1;
        tbl_rsp_data = {3'b101, 17'(frame_of((int'(last_rd_addr) - m_base) >>> 3)), 12'hABC};
        @(negedge clk);
        tbl_rsp_valid = 1'b0;
        tbl_rsp_data = '0;
      end
    end
  end

  // per-cycle comparison against the model's expectations
  always @(negedge clk) begin
    if (rst_n && tbl_rd_valid) check(m_inflight, "R11 read without pending miss", 1, 0);
    if (rst_n && xl_done) check(m_done_ok, "R7 unexpected result pulse", 1, 0);
  end

  task automatic cfg_write(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = d;
    if (a == 0) m_base = d & 32'h1FFFFFFF;
    if (a == 1) m_limit = d;
    if (a == 2) begin m_cache.delete(); if (m_inflight) m_stale = 1; end
    if (a == 3) m_flag = 0;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(int a, output int d);
    @(negedge clk);
    cfg_addr = 2'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic xlate(int la, string tag);
    int idx = la >>> 12;
    bit err = (longint'(idx) * 8) >= longint'(unsigned'(m_limit));
    bit hit = 0;
    int rd0 = n_reads;
    int tmo = 0;
    longint exp_pa;
    foreach (m_cache[i]) if (m_cache[i] == idx) hit = 1;
    m_stale = 0;
    m_inflight = !err && !hit;
    @(negedge clk);
    while (!xl_ready) @(negedge clk);
    m_done_ok = 1;
    xl_valid = 1'b1; xl_laddr = 24'(la);
    @(negedge clk);
    xl_valid = 1'b0;
    if (m_inflight) check(xl_ready == 1'b0, {tag, " R11 ready low during miss"}, xl_ready, 0);
    while (!xl_done && tmo < 200) begin @(negedge clk); tmo++; end
    check(xl_done, {tag, " result arrives"}, xl_done, 1);
    if (err) begin
      m_flag = 1; m_fault = la;
      check(xl_fault && xl_paddr == 0, {tag, " R3 fault result"}, {xl_fault, xl_paddr}, {1'b1, 29'h0});
      check(n_reads == rd0, {tag, " R3 no table read"}, n_reads - rd0, 0);
    end else begin
      exp_pa = (longint'(frame_of(idx)) << 12) | (la & 12'hFFF);
      check(!xl_fault && xl_paddr == 29'(exp_pa), {tag, " R6 physical address"}, xl_paddr, exp_pa);
      if (hit) check(n_reads == rd0, {tag, " R7 hit needs no read"}, n_reads - rd0, 0);
      else begin
        check(n_reads == rd0 + 1, {tag, " R5 one read per miss"}, n_reads - rd0, 1);
        check(last_rd_addr == 29'(m_base + idx * 8), {tag, " R5 entry address"},
              last_rd_addr, m_base + idx * 8);
        if (!m_stale) begin
          m_cache.push_back(idx);
          if (m_cache.size() > 4) void'(m_cache.pop_front());
        end
      end
    end
    @(negedge clk);
    m_done_ok = 0;
    m_inflight = 0;
    check(addr_err_o == m_flag, {tag, " R4 error flag"}, addr_err_o, m_flag);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d;
    int rb0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(xl_ready && !xl_done && !addr_err_o, "R1 reset outputs", {xl_ready, xl_done, addr_err_o}, 3'b100);
    cfg_read(0, d); check(d == 0, "R1 base reset", d, 0);
    cfg_read(1, d); check(d == 0, "R1 limit reset", d, 0);
    cfg_read(3, d); check(d == 0, "R1 fault reset", d, 0);

    // R2 register readback
    cfg_write(0, 32'hFFFFFFFF);
    cfg_read(0, d); check(d == 32'h1FFFFFFF, "R2 base width", d, 32'h1FFFFFFF);
    cfg_write(1, 32'h8000);
    cfg_read(1, d); check(d == 32'h8000, "R2 limit readback", d, 32'h8000);
    cfg_read(2, d); check(d == 0, "R2 invalidate reads zero", d, 0);
    cfg_write(0, 32'h0100_0000);

    // R5 R6 R7 miss then hit
    xlate(24'h000123, "miss0");
    xlate(24'h000FFF, "hit0");
    rd_lat = 2; rsp_lat = 3;
    xlate(24'h005ABC, "slowmiss");
    xlate(24'hFFFFFF, "toppage");
    rd_lat = 0; rsp_lat = 0;

    // R9 invalidate empties cache
    cfg_write(2, 32'h1234);
    rb0 = n_reads;
    xlate(24'h000456, "R9 refetch");
    check(n_reads == rb0 + 1, "R9 read after invalidate", n_reads - rb0, 1);

    // R8 round-robin replacement
    xlate(24'h001000, "rr1");
    xlate(24'h002000, "rr2");
    xlate(24'h003000, "rr3");
    xlate(24'h000010, "rr hit0");
    xlate(24'h004000, "rr4");
    rb0 = n_reads;
    xlate(24'h000020, "R8 evicted oldest");
    check(n_reads == rb0 + 1, "R8 oldest fill evicted despite hit", n_reads - rb0, 1);
    rb0 = n_reads;
    xlate(24'h004777, "R8 newest kept");
    check(n_reads == rb0, "R8 recent fill kept", n_reads - rb0, 0);

    // R3 R4 limit boundary and sticky flag
    cfg_write(1, 32'h100);
    xlate(24'h01F001, "R3 last in range");
    xlate(24'h020002, "R3 first out of range");
    cfg_read(3, d); check(d == 32'h020002, "R3 fault address", d, 32'h020002);
    xlate(24'h004010, "R4 ok keeps flag");
    check(addr_err_o == 1'b1, "R4 flag still set", addr_err_o, 1);
    cfg_write(3, 0);
    check(addr_err_o == 1'b0, "R4 flag cleared by write", addr_err_o, 0);
    cfg_read(3, d); check(d == 32'h020002, "R4 fault address kept", d, 32'h020002);

    // R10 invalidate while fetch outstanding
    cfg_write(1, 32'h8000);
    rsp_lat = 5;
    fork
      xlate(24'h00A0AA, "R10 stale fetch");
      begin
        while (!tbl_rd_valid) @(negedge clk);
        cfg_write(2, 0);
      end
    join
    rsp_lat = 0;
    rb0 = n_reads;
    xlate(24'h00A0BB, "R10 not installed");
    check(n_reads == rb0 + 1, "R10 stale entry not cached", n_reads - rb0, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule